// File: doc/BRIEF.md
# Reservation Monitor for Linked Load / Conditional Store

This block sits beside a small shared word memory and lets several requesters build atomic updates out of two ordinary accesses instead of one indivisible read-modify-write. A requester issues a linked load, which returns the word and opens a reservation on that word in a per-requester link register. Later it issues a conditional store. The store writes memory, and the response reports success, only if the reservation is still standing. If the reservation is gone, the store reports failure and memory is left alone.

Reservations are broken by anything that could have changed the reserved word behind the owner's back. That covers a plain store or a successful conditional store from another requester to the same word, and an interrupt or context-switch pulse on the owner's cancel input. Every requester may issue one request per cycle. Requests arriving in the same cycle are ordered as follows: all reads come first, then all writes in ascending requester index. Each request gets a registered response exactly one cycle later.

Top module: `llsc_monitor`

## Requirements
- R1: A linked load (op code 2'b10) returns, one cycle later on rsp_rdata, the addressed word as it stood before any write of the same cycle, and opens a reservation on that word for its requester; a plain load (op code 2'b00) returns data the same way without touching reservations.
- R2: A conditional store (op code 2'b11) writes its data and raises rsp_ok one cycle later when its requester holds a reservation on the same word and no lower-index requester writes that word in the same cycle.
- R3: A conditional store that does not meet R2 leaves rsp_ok low and leaves the memory word unchanged.
- R4: A plain store (op code 2'b01) or a successful conditional store by another requester to a reserved word clears that reservation, including a reservation opened in the same cycle; a requester's own plain store keeps its reservation.
- R5: A high cancel bit clears that requester's reservation and takes precedence over a linked load in the same cycle.
- R6: Every conditional store clears its own requester's reservation, whether it succeeds or fails.
- R7: Addresses are byte addresses; matching and memory indexing use only the word index addr[AW-1:WB], so addresses that differ only in the low WB bits refer to the same word.
- R8: Within one cycle, writes take effect in ascending requester index: of two eligible conditional stores to one word, only the lower index succeeds, and the word ends up holding the data of the highest-index effective writer.
- R9: After reset, rsp_valid and rsp_ok are low and no reservation exists, so a conditional store fails.
- R10: rsp_valid follows req_valid by one cycle; rsp_ok is only ever high for a conditional store; rsp_rdata is zero for plain and conditional stores.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_op | input | 2*NREQ | Op code per requester: 00 load, 01 store, 10 linked load, 11 conditional store |
| req_addr | input | AW*NREQ | Byte address per requester |
| req_wdata | input | DW*NREQ | Store data per requester |
| cancel | input | NREQ | Interrupt or context switch of the requester; clears its reservation |
| rsp_valid | output | NREQ | Response present, one cycle after the request |
| rsp_ok | output | NREQ | Conditional store succeeded |
| rsp_rdata | output | DW*NREQ | Load data, zero for stores |

## Verification
The bench aims at the orderings that break reservations in the same cycle they would be used. These are two conditional stores to one word, where a design without ordering would let both succeed and corrupt the word. A linked load colliding with another requester's store would leave a stale reservation that lets a later conditional store succeed wrongly. A cancel arriving together with a linked load would survive if the set were given priority. The bench also targets byte addresses that differ only in the low bits, which a full-address compare would reject, and a requester's own store to its reserved word, which must not break the reservation. Random traffic confined to a few words keeps all of these collisions frequent.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } op_e;
endpackage

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
  parameter int NREQ = 4,
  parameter int IW   = 4,
  parameter int DW   = 32
) (
  input  logic               clk,
  input  logic [NREQ-1:0]    wr_en,
  input  logic [NREQ*IW-1:0] wr_idx,
  input  logic [NREQ*DW-1:0] wr_data,
  input  logic [NREQ*IW-1:0] rd_idx,
  output logic [NREQ*DW-1:0] rd_data
);
  localparam int WORDS = 1 << IW;

  logic [DW-1:0] mem_q [WORDS];

  // Writes land in ascending index order; the last one to a word wins.
  always_ff @(posedge clk) begin
    for (int i = 0; i < NREQ; i++) begin
      if (wr_en[i]) begin
        mem_q[wr_idx[i*IW +: IW]] <= wr_data[i*DW +: DW];
      end
    end
  end

  // Reads see the contents before this cycle's writes.
  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      rd_data[i*DW +: DW] = mem_q[rd_idx[i*IW +: IW]];
    end
  end
endmodule

// File: rtl/llsc_order_resolve.sv
module llsc_order_resolve #(
  parameter int NREQ = 4,
  parameter int IW   = 4
) (
  input  logic [NREQ-1:0]    is_store,
  input  logic [NREQ-1:0]    is_cond,
  input  logic [NREQ*IW-1:0] req_idx,
  input  logic [NREQ-1:0]    link_vld,
  input  logic [NREQ*IW-1:0] link_idx,
  output logic [NREQ-1:0]    wr_en,
  output logic [NREQ-1:0]    cond_ok
);
  logic [NREQ-1:0] wr_v;
  logic [NREQ-1:0] ok_v;

  // Walk requesters in ascending order; an earlier write to the same
  // word breaks a later conditional store.
  always_comb begin
    wr_v = '0;
    ok_v = '0;
    for (int i = 0; i < NREQ; i++) begin
      logic blocked;
      logic eligible;
      blocked = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (wr_v[j] && (req_idx[j*IW +: IW] == req_idx[i*IW +: IW])) begin
          blocked = 1'b1;
        end
      end
      eligible = is_cond[i] && link_vld[i] &&
                 (link_idx[i*IW +: IW] == req_idx[i*IW +: IW]);
      ok_v[i] = eligible && !blocked;
      wr_v[i] = is_store[i] || ok_v[i];
    end
  end

  assign wr_en   = wr_v;
  assign cond_ok = ok_v;
endmodule

// File: rtl/llsc_link_reg.sv
module llsc_link_reg #(
  parameter int NREQ = 4,
  parameter int IW   = 4,
  parameter int SELF = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cancel,
  input  logic               set_link,
  input  logic               own_cond,
  input  logic [IW-1:0]      req_idx,
  input  logic [NREQ-1:0]    wr_en,
  input  logic [NREQ*IW-1:0] wr_idx,
  output logic               link_vld,
  output logic [IW-1:0]      link_idx
);
  logic          vld_q, vld_d;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] watch_idx;
  logic          foreign_hit;

  assign watch_idx = set_link ? req_idx : idx_q;

  always_comb begin
    foreign_hit = 1'b0;
    for (int j = 0; j < NREQ; j++) begin
      if ((j != SELF) && wr_en[j] && (wr_idx[j*IW +: IW] == watch_idx)) begin
        foreign_hit = 1'b1;
      end
    end
  end

  always_comb begin
    if (cancel || own_cond) begin
      vld_d = 1'b0;
    end else if (set_link) begin
      vld_d = !foreign_hit;
    end else begin
      vld_d = vld_q && !foreign_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (set_link) begin
      idx_q <= req_idx;
    end
  end

  assign link_vld = vld_q;
  assign link_idx = idx_q;
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NREQ = 4,
  parameter int AW   = 6,
  parameter int WB   = 2,
  parameter int DW   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREQ-1:0]    req_valid,
  input  logic [NREQ*2-1:0]  req_op,
  input  logic [NREQ*AW-1:0] req_addr,
  input  logic [NREQ*DW-1:0] req_wdata,
  input  logic [NREQ-1:0]    cancel,
  output logic [NREQ-1:0]    rsp_valid,
  output logic [NREQ-1:0]    rsp_ok,
  output logic [NREQ*DW-1:0] rsp_rdata
);
  import llsc_pkg::*;

  localparam int IW = AW - WB;

  logic [NREQ-1:0]    is_store, is_cond, is_link, is_read;
  logic [NREQ*IW-1:0] req_idx;
  logic [NREQ*WB-1:0] addr_offset_unused;
  logic [NREQ-1:0]    link_vld;
  logic [NREQ*IW-1:0] link_idx;
  logic [NREQ-1:0]    wr_en, cond_ok;
  logic [NREQ*DW-1:0] rd_data;

  logic [NREQ-1:0]    rsp_valid_q, rsp_valid_d;
  logic [NREQ-1:0]    rsp_ok_q, rsp_ok_d;
  logic [NREQ*DW-1:0] rsp_rdata_q, rsp_rdata_d;

  for (genvar g = 0; g < NREQ; g++) begin : g_dec
    op_e op;
    assign op = op_e'(req_op[g*2 +: 2]);
    assign is_store[g] = req_valid[g] && (op == OP_STORE);
    assign is_cond[g]  = req_valid[g] && (op == OP_COND);
    assign is_link[g]  = req_valid[g] && (op == OP_LINK);
    assign is_read[g]  = req_valid[g] && ((op == OP_LOAD) || (op == OP_LINK));
    assign req_idx[g*IW +: IW] = req_addr[g*AW + WB +: IW];
    assign addr_offset_unused[g*WB +: WB] = req_addr[g*AW +: WB];
  end

  llsc_order_resolve #(.NREQ(NREQ), .IW(IW)) u_resolve (
    .is_store (is_store),
    .is_cond  (is_cond),
    .req_idx  (req_idx),
    .link_vld (link_vld),
    .link_idx (link_idx),
    .wr_en    (wr_en),
    .cond_ok  (cond_ok)
  );

  for (genvar g = 0; g < NREQ; g++) begin : g_link
    llsc_link_reg #(.NREQ(NREQ), .IW(IW), .SELF(g)) u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .cancel   (cancel[g]),
      .set_link (is_link[g]),
      .own_cond (is_cond[g]),
      .req_idx  (req_idx[g*IW +: IW]),
      .wr_en    (wr_en),
      .wr_idx   (req_idx),
      .link_vld (link_vld[g]),
      .link_idx (link_idx[g*IW +: IW])
    );
  end

  llsc_word_mem #(.NREQ(NREQ), .IW(IW), .DW(DW)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (req_idx),
    .wr_data (req_wdata),
    .rd_idx  (req_idx),
    .rd_data (rd_data)
  );

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_ok_d    = cond_ok;
    for (int i = 0; i < NREQ; i++) begin
      rsp_rdata_d[i*DW +: DW] = is_read[i] ? rd_data[i*DW +: DW] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= '0;
      rsp_ok_q    <= '0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_ok_q    <= rsp_ok_d;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_ok    = rsp_ok_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NREQ = 4,
  parameter int AW   = 6,
  parameter int WB   = 2,
  parameter int DW   = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NREQ-1:0]            req_valid,
  input logic [NREQ*2-1:0]          req_op,
  input logic [NREQ*AW-1:0]         req_addr,
  input logic [NREQ-1:0]            cancel,
  input logic [NREQ-1:0]            rsp_ok,
  input logic [NREQ-1:0]            link_vld,
  input logic [NREQ*(AW-WB)-1:0]    link_idx
);
  localparam int IW = AW - WB;

  logic [NREQ*WB-1:0] chk_offset_unused;
  for (genvar g = 0; g < NREQ; g++) begin : g_off
    assign chk_offset_unused[g*WB +: WB] = req_addr[g*AW +: WB];
  end

  for (genvar i = 0; i < NREQ; i++) begin : g_one
    // R3 / R10: success only for a conditional store that held a reservation
    a_r3_ok_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ok[i] |-> $past(req_valid[i] && (req_op[i*2 +: 2] == 2'b11) && link_vld[i]));

    // R5: cancel leaves no reservation
    a_r5_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cancel[i]) |-> !link_vld[i]);

    // R6: conditional store always drops own reservation
    a_r6_cond_clears_own: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid[i] && (req_op[i*2 +: 2] == 2'b11)) |-> !link_vld[i]);

    // R1: a reservation opened by a linked load points at its word
    a_r1_link_word: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req_valid[i] && (req_op[i*2 +: 2] == 2'b10)) && link_vld[i])
      |-> (link_idx[i*IW +: IW] == $past(req_addr[i*AW + WB +: IW])));

    for (genvar j = i + 1; j < NREQ; j++) begin : g_pair
      // R8: two successes in one cycle never share a word
      a_r8_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ok[i] && rsp_ok[j])
        |-> ($past(req_addr[i*AW + WB +: IW]) != $past(req_addr[j*AW + WB +: IW])));
    end
  end
endmodule

bind llsc_monitor llsc_monitor_chk #(.NREQ(NREQ), .AW(AW), .WB(WB), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .cancel    (cancel),
  .rsp_ok    (rsp_ok),
  .link_vld  (link_vld),
  .link_idx  (link_idx)
);

// File: tb/llsc_monitor_bench.sv
`timescale 1ns/1ps
module llsc_monitor_bench;
  localparam int N  = 4;
  localparam int AW = 6;
  localparam int WB = 2;
  localparam int DW = 32;
  localparam int IW = AW - WB;
  localparam int WORDS = 1 << IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]    b_valid;
  logic [1:0]      b_op    [N];
  logic [AW-1:0]   b_addr  [N];
  logic [DW-1:0]   b_wd    [N];
  logic [N-1:0]    b_cancel;

  logic [N*2-1:0]  req_op;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_wdata;
  logic [N-1:0]    rsp_valid, rsp_ok;
  logic [N*DW-1:0] rsp_rdata;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      req_op[i*2 +: 2]     = b_op[i];
      req_addr[i*AW +: AW] = b_addr[i];
      req_wdata[i*DW +: DW] = b_wd[i];
    end
  end

  llsc_monitor #(.NREQ(N), .AW(AW), .WB(WB), .DW(DW)) u_llsc_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .cancel(b_cancel),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata)
  );

  // reference model state
  logic [DW-1:0]  m_mem [WORDS];
  logic           m_lv  [N];
  logic [IW-1:0]  m_li  [N];
  logic           e_valid [N];
  logic           e_ok    [N];
  logic [DW-1:0]  e_rd    [N];
  logic [1:0]     e_op    [N];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic logic [IW-1:0] widx(input logic [AW-1:0] a);
    return a[AW-1:WB];
  endfunction

  task automatic m_write(input int who, input logic [IW-1:0] w, input logic [DW-1:0] d);
    m_mem[w] = d;
    for (int k = 0; k < N; k++)
      if (k != who && m_lv[k] && m_li[k] == w) m_lv[k] = 1'b0;
  endtask

  // Sequential statement of the ordering rules: reads, then writes by index, then cancels.
  task automatic m_step();
    for (int i = 0; i < N; i++) begin
      e_valid[i] = b_valid[i]; e_ok[i] = 1'b0; e_rd[i] = '0; e_op[i] = b_op[i];
    end
    for (int i = 0; i < N; i++) begin
      if (b_valid[i] && (b_op[i] == 2'b00 || b_op[i] == 2'b10))
        e_rd[i] = m_mem[widx(b_addr[i])];
      if (b_valid[i] && b_op[i] == 2'b10) begin
        m_lv[i] = 1'b1; m_li[i] = widx(b_addr[i]);
      end
    end
    for (int i = 0; i < N; i++) begin
      if (b_valid[i] && b_op[i] == 2'b01) m_write(i, widx(b_addr[i]), b_wd[i]);
      if (b_valid[i] && b_op[i] == 2'b11) begin
        if (m_lv[i] && m_li[i] == widx(b_addr[i])) begin
          e_ok[i] = 1'b1;
          m_write(i, widx(b_addr[i]), b_wd[i]);
        end
        m_lv[i] = 1'b0;
      end
    end
    for (int i = 0; i < N; i++) if (b_cancel[i]) m_lv[i] = 1'b0;
  endtask

  task automatic check(input string tag, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    b_valid = '0; b_cancel = '0;
    for (int i = 0; i < N; i++) begin
      b_op[i] = 2'b00; b_addr[i] = '0; b_wd[i] = '0;
    end
  endtask

  // Apply current inputs for one cycle and compare the registered response.
  task automatic tick(input string tag);
    string t;
    m_step();
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      t = tag;
      if (t == "") begin
        if (e_op[i] == 2'b11) t = e_ok[i] ? "R2" : "R3";
        else if (e_op[i] == 2'b01) t = "R10";
        else t = "R1";
      end
      check(t, $sformatf("rsp_valid[%0d]", i), DW'(rsp_valid[i]), DW'(e_valid[i]));
      if (e_valid[i]) begin
        check(t, $sformatf("rsp_ok[%0d]", i), DW'(rsp_ok[i]), DW'(e_ok[i]));
        check(t, $sformatf("rsp_rdata[%0d]", i), rsp_rdata[i*DW +: DW], e_rd[i]);
      end
    end
    idle();
  endtask

  task automatic req(input int who, input logic [1:0] op, input logic [AW-1:0] a,
                     input logic [DW-1:0] d);
    b_valid[who] = 1'b1; b_op[who] = op; b_addr[who] = a; b_wd[who] = d;
  endtask

  task automatic load_check(input int w, input string tag);
    req(0, 2'b00, AW'(w << WB), '0);
    tick(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    idle();
    for (int i = 0; i < N; i++) begin m_lv[i] = 1'b0; m_li[i] = '0; end
    for (int w = 0; w < WORDS; w++) m_mem[w] = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "rsp_valid in reset", DW'(rsp_valid), '0);
    check("R9", "rsp_ok in reset", DW'(rsp_ok), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill memory so every word has a known value
    for (int w = 0; w < WORDS; w += N) begin
      for (int i = 0; i < N; i++) req(i, 2'b01, AW'((w + i) << WB), $urandom);
      tick("R10");
    end

    // R9: conditional store with no reservation after reset fails
    req(0, 2'b11, AW'(0), 32'hdead_0001); tick("R9");
    load_check(0, "R3");

    // R1/R2: linked load then conditional store succeeds
    req(0, 2'b10, AW'(1 << WB), '0); tick("R1");
    req(0, 2'b11, AW'(1 << WB), 32'haaaa_0001); tick("R2");
    load_check(1, "R2");

    // R4/R3: other requester's store kills the reservation, memory untouched
    req(0, 2'b10, AW'(2 << WB), '0); tick("R1");
    req(1, 2'b01, AW'(2 << WB), 32'h1111_2222); tick("R4");
    req(0, 2'b11, AW'(2 << WB), 32'hbad0_0002); tick("R4");
    load_check(2, "R3");

    // R5: cancel after link, and cancel together with link
    req(2, 2'b10, AW'(3 << WB), '0); tick("R1");
    b_cancel[2] = 1'b1; tick("R5");
    req(2, 2'b11, AW'(3 << WB), 32'hbad0_0003); tick("R5");
    req(2, 2'b10, AW'(3 << WB), '0); b_cancel[2] = 1'b1; tick("R5");
    req(2, 2'b11, AW'(3 << WB), 32'hbad0_0004); tick("R5");
    load_check(3, "R5");

    // R6: second conditional store after a success fails
    req(1, 2'b10, AW'(4 << WB), '0); tick("R1");
    req(1, 2'b11, AW'(4 << WB), 32'h4444_0001); tick("R6");
    req(1, 2'b11, AW'(4 << WB), 32'hbad0_0005); tick("R6");
    load_check(4, "R6");

    // R7: byte offsets within a word still match
    req(3, 2'b10, AW'((5 << WB) | 0), '0); tick("R7");
    req(3, 2'b11, AW'((5 << WB) | 3), 32'h5555_0007); tick("R7");
    load_check(5, "R7");

    // R8: two conditional stores to one word in one cycle
    req(1, 2'b10, AW'(6 << WB), '0); req(2, 2'b10, AW'((6 << WB) | 1), '0); tick("R8");
    req(1, 2'b11, AW'(6 << WB), 32'h6666_0001); req(2, 2'b11, AW'(6 << WB), 32'h6666_0002);
    tick("R8");
    load_check(6, "R8");
    // R8: two plain stores, highest index lands
    req(0, 2'b01, AW'(6 << WB), 32'h0000_0a0a); req(3, 2'b01, AW'(6 << WB), 32'h0000_0b0b);
    tick("R8");
    load_check(6, "R8");

    // R4: own store keeps the reservation
    req(0, 2'b10, AW'(7 << WB), '0); tick("R1");
    req(0, 2'b01, AW'(7 << WB), 32'h7777_0001); tick("R4");
    req(0, 2'b11, AW'(7 << WB), 32'h7777_0002); tick("R4");
    load_check(7, "R4");

    // R4: link in the same cycle as another requester's store is dead
    req(0, 2'b10, AW'(8 << WB), '0); req(1, 2'b01, AW'(8 << WB), 32'h8888_0001); tick("R4");
    req(0, 2'b11, AW'(8 << WB), 32'hbad0_0008); tick("R4");
    load_check(8, "R4");

    // random traffic on a few words for frequent collisions
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < N; i++) begin
        if (($urandom % 4) != 0)
          req(i, 2'($urandom), AW'((($urandom % 3) << WB) | ($urandom % (1 << WB))), $urandom);
        b_cancel[i] = (($urandom % 10) == 0);
      end
      tick("");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule